// File: doc/BRIEF.md
# Per-Core Interrupt Delivery Front End

This block sits between a shared interrupt state tracker and one processor core. Each cycle it looks at the tracker's pending vector, the per-line enables, the per-line priorities and the per-line core-routing masks. From these it picks the most urgent interrupt that is pending, enabled and routed to its own core. When that winner beats the core's priority threshold and no earlier interrupt is still being serviced, it raises the core's IRQ request.

Software on the core uses a small register port with three locations. Reading the claim location returns the winner's interrupt number, which is the line index plus 32, and sends a one-cycle claim pulse on that line to the tracker. Writing an interrupt number to the completion location sends a one-cycle completion pulse back and frees the interface. The threshold location holds the priority mask. At most one interrupt is in service at a time. Nesting and preemption are not supported.

Top module: `intc_cpuif`

## Requirements
- R1: When internal reset is released, `irq_o` is 0, `ack_vec_o` and `eoi_vec_o` are 0, `bus_rdata_o` is 0, and the threshold register reads 0.
- R2: Among candidates, the numerically lowest priority value wins.
- R3: When candidates have equal priority, the lowest line index wins.
- R4: A line is a candidate only if bit `line*NUM_CORES+CORE_ID` of `target_i` is 1.
- R5: A line is a candidate only if both `pend_i` and `enable_i` are 1 for that line.
- R6: `irq_o` (combinational) is 1 only when a candidate exists, no interrupt is in service, and the winner's priority is strictly less than the threshold.
- R7: A read at address 0, in a cycle where `irq_o` is 1, does three things. On the next edge it loads `bus_rdata_o` with 32 plus the winner's index. In the same cycle it pulses the winner's bit alone in `ack_vec_o`. It also marks that interrupt as in service.
- R8: A read at address 0 while `irq_o` is 0 loads 1023 into `bus_rdata_o`, gives no claim pulse and changes no state.
- R9: While an interrupt is in service, `irq_o` stays 0 and claim reads return 1023.
- R10: A write at address 1 whose data equals 32 plus the in-service line index does two things. On the next edge it pulses that line's bit alone in `eoi_vec_o`. It also ends the in-service state.
- R11: A write at address 1 with any other value, or with nothing in service, gives no completion pulse and leaves the in-service state unchanged.
- R12: A write at address 2 loads the low `PRIO_W` bits of the data into the threshold. A read at address 2 returns the threshold zero-extended. A read at address 3 returns 0. Every register read lands in `bus_rdata_o` one edge later, and the value holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pend_i | input | NUM_LINES | Pending state per line from the tracker |
| enable_i | input | NUM_LINES | Enable per line |
| prio_i | input | NUM_LINES*PRIO_W | Priority per line, line i at bits [i*PRIO_W +: PRIO_W] |
| target_i | input | NUM_LINES*NUM_CORES | Core routing mask, line i core c at bit i*NUM_CORES+c |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 claim, 1 completion, 2 threshold |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered |
| irq_o | output | 1 | Interrupt request to the core |
| ack_vec_o | output | NUM_LINES | One-cycle claim pulse to the tracker |
| eoi_vec_o | output | NUM_LINES | One-cycle completion pulse to the tracker |

## Verification
The embedded properties check several rules on every cycle. Claim and completion pulses are at most one-hot. A claim pulse only follows a cycle in which the request was raised. A completion pulse only follows an in-service state. The request stays low while the threshold is zero. The named winner is always pending, enabled and routed here. Only the bench's reference model can show the winner's identity under priority ties and routing. The same holds for the exact number returned by claim reads, the strict threshold comparison, and the rejection of completion writes with the wrong number. The bench compares all outputs with that model on every clock, over directed and random traffic.

// File: rtl/intc_cpuif_pkg.sv
package intc_cpuif_pkg;
  localparam int unsigned ID_BASE     = 32;
  localparam int unsigned SPURIOUS_ID = 1023;

  typedef enum logic [1:0] {
    REG_CLAIM  = 2'd0,
    REG_DONE   = 2'd1,
    REG_THRESH = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/intc_cpuif_select.sv
module intc_cpuif_select #(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 8,
  parameter int NUM_CORES = 4,
  parameter int CORE_ID   = 0,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]           pend_i,
  input  logic [NUM_LINES-1:0]           enable_i,
  input  logic [NUM_LINES*PRIO_W-1:0]    prio_i,
  input  logic [NUM_LINES*NUM_CORES-1:0] target_i,
  output logic                           cand_valid_o,
  output logic [IDX_W-1:0]               cand_idx_o,
  output logic [PRIO_W-1:0]              cand_prio_o
);
  logic [NUM_LINES-1:0] eligible;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_elig
      assign eligible[g] = pend_i[g] & enable_i[g] & target_i[g*NUM_CORES + CORE_ID];
    end
  endgenerate

  // Linear scan, strict compare keeps the lowest index on ties (R3)
  always_comb begin
    cand_valid_o = 1'b0;
    cand_idx_o   = '0;
    cand_prio_o  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (eligible[i] && (!cand_valid_o || prio_i[i*PRIO_W +: PRIO_W] < cand_prio_o)) begin
        cand_valid_o = 1'b1;
        cand_idx_o   = IDX_W'(i);
        cand_prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intc_cpuif_ctrl.sv
module intc_cpuif_ctrl
  import intc_cpuif_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 8,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [1:0]           bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  input  logic                 cand_valid_i,
  input  logic [IDX_W-1:0]     cand_idx_i,
  input  logic [PRIO_W-1:0]    cand_prio_i,
  output logic                 irq_o,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic [NUM_LINES-1:0] ack_vec_o,
  output logic [NUM_LINES-1:0] eoi_vec_o,
  output logic [PRIO_W-1:0]    pmr_o
);
  localparam logic [NUM_LINES-1:0] ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

  logic [PRIO_W-1:0]    pmr_q, pmr_d;
  logic                 busy_q, busy_d;
  logic [IDX_W-1:0]     act_q, act_d;
  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic [NUM_LINES-1:0] ack_q, ack_d, eoi_q, eoi_d;

  logic rd_en, wr_en, qualify, eoi_hit;

  assign rd_en   = bus_sel_i & ~bus_wr_i;
  assign wr_en   = bus_sel_i &  bus_wr_i;
  assign qualify = cand_valid_i & ~busy_q & (cand_prio_i < pmr_q);
  assign eoi_hit = wr_en & (bus_addr_i == REG_DONE) & busy_q &
                   (bus_wdata_i == DATA_W'(ID_BASE) + DATA_W'(act_q));

  always_comb begin
    pmr_d   = pmr_q;
    busy_d  = busy_q;
    act_d   = act_q;
    rdata_d = rdata_q;
    ack_d   = '0;
    eoi_d   = '0;
    if (rd_en) begin
      unique case (bus_addr_i)
        REG_CLAIM: begin
          if (qualify) begin
            rdata_d = DATA_W'(ID_BASE) + DATA_W'(cand_idx_i);
            ack_d   = ONE << cand_idx_i;
            busy_d  = 1'b1;
            act_d   = cand_idx_i;
          end else begin
            rdata_d = DATA_W'(SPURIOUS_ID);
          end
        end
        REG_THRESH: rdata_d = DATA_W'(pmr_q);
        default:    rdata_d = '0;
      endcase
    end
    if (wr_en && bus_addr_i == REG_THRESH) pmr_d = bus_wdata_i[PRIO_W-1:0];
    if (eoi_hit) begin
      eoi_d  = ONE << act_q;
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmr_q   <= '0;
      busy_q  <= 1'b0;
      act_q   <= '0;
      rdata_q <= '0;
      ack_q   <= '0;
      eoi_q   <= '0;
    end else begin
      pmr_q   <= pmr_d;
      busy_q  <= busy_d;
      act_q   <= act_d;
      rdata_q <= rdata_d;
      ack_q   <= ack_d;
      eoi_q   <= eoi_d;
    end
  end

  assign irq_o       = qualify;
  assign bus_rdata_o = rdata_q;
  assign ack_vec_o   = ack_q;
  assign eoi_vec_o   = eoi_q;
  assign pmr_o       = pmr_q;

  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec_o));
  assert_ack_after_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_vec_o) |-> $past(irq_o));
  assert_claim_blocks_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_vec_o) |-> !irq_o);
  assert_eoi_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoi_vec_o));
  assert_eoi_needs_service_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|eoi_vec_o) |-> $past(busy_q));
endmodule

// File: rtl/intc_cpuif.sv
module intc_cpuif #(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 8,
  parameter int NUM_CORES = 4,
  parameter int CORE_ID   = 1,
  parameter int DATA_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_LINES-1:0]           pend_i,
  input  logic [NUM_LINES-1:0]           enable_i,
  input  logic [NUM_LINES*PRIO_W-1:0]    prio_i,
  input  logic [NUM_LINES*NUM_CORES-1:0] target_i,
  input  logic                           bus_sel_i,
  input  logic                           bus_wr_i,
  input  logic [1:0]                     bus_addr_i,
  input  logic [DATA_W-1:0]              bus_wdata_i,
  output logic [DATA_W-1:0]              bus_rdata_o,
  output logic                           irq_o,
  output logic [NUM_LINES-1:0]           ack_vec_o,
  output logic [NUM_LINES-1:0]           eoi_vec_o
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic              rst_meta_q, rst_sync_q;
  logic              cand_valid;
  logic [IDX_W-1:0]  cand_idx;
  logic [PRIO_W-1:0] cand_prio;
  logic [PRIO_W-1:0] pmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  intc_cpuif_select #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .NUM_CORES(NUM_CORES),
    .CORE_ID(CORE_ID), .IDX_W(IDX_W)
  ) u_select (
    .pend_i(pend_i), .enable_i(enable_i), .prio_i(prio_i), .target_i(target_i),
    .cand_valid_o(cand_valid), .cand_idx_o(cand_idx), .cand_prio_o(cand_prio)
  );

  intc_cpuif_ctrl #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_q),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .cand_valid_i(cand_valid), .cand_idx_i(cand_idx), .cand_prio_i(cand_prio),
    .irq_o(irq_o), .bus_rdata_o(bus_rdata_o),
    .ack_vec_o(ack_vec_o), .eoi_vec_o(eoi_vec_o), .pmr_o(pmr)
  );

  assert_zero_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pmr == '0) |-> !irq_o);
  assert_winner_eligible_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cand_valid |-> (pend_i[cand_idx] && enable_i[cand_idx]));
  assert_winner_routed_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cand_valid |-> target_i[32'(cand_idx)*NUM_CORES + CORE_ID]);
endmodule

// File: tb/intc_cpuif_tb_top.sv
module intc_cpuif_tb_top;
  localparam int N  = 16;
  localparam int PW = 8;
  localparam int NC = 4;
  localparam int ME = 1;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    pend, en;
  logic [N*PW-1:0] prio;
  logic [N*NC-1:0] tgt;
  logic            sel, wr;
  logic [1:0]      addr;
  logic [DW-1:0]   wdata, rdata;
  logic            irq;
  logic [N-1:0]    ackv, eoiv;

  always #4 clk = ~clk;

  intc_cpuif #(.NUM_LINES(N), .PRIO_W(PW), .NUM_CORES(NC), .CORE_ID(ME), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .enable_i(en), .prio_i(prio), .target_i(tgt),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .ack_vec_o(ackv), .eoi_vec_o(eoiv)
  );

  int checks = 0, fails = 0;
  string req = "R1";
  // reference model state
  int m_pmr = 0, m_busy = 0, m_act = 0;
  int e_rdata = 0;
  logic [N-1:0] e_ack = '0, e_eoi = '0;

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
    end
  endtask

  function automatic int winner();
    int best = -1, bp = 0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && en[i] && tgt[i*NC+ME] && (best < 0 || int'(prio[i*PW +: PW]) < bp)) begin
        best = i;
        bp   = int'(prio[i*PW +: PW]);
      end
    end
    return best;
  endfunction

  function automatic bit m_irq();
    int w = winner();
    return (w >= 0) && (m_busy == 0) && (int'(prio[w*PW +: PW]) < m_pmr);
  endfunction

  // called just after a negedge with inputs set; ends just after the next negedge
  task automatic cycle();
    int w;
    bit q;
    #3;
    q = m_irq();
    chk(req, "irq", irq, q);
    w = winner();
    e_ack = '0;
    e_eoi = '0;
    if (sel && !wr) begin
      if (addr == 2'd0) begin
        if (q) begin e_rdata = 32 + w; e_ack[w] = 1'b1; m_busy = 1; m_act = w; end
        else e_rdata = 1023;
      end else if (addr == 2'd2) e_rdata = m_pmr;
      else e_rdata = 0;
    end
    if (sel && wr && addr == 2'd2) m_pmr = int'(wdata[PW-1:0]);
    if (sel && wr && addr == 2'd1 && m_busy == 1 && int'(wdata) == 32 + m_act) begin
      e_eoi[m_act] = 1'b1;
      m_busy = 0;
    end
    @(posedge clk);
    #1;
    chk(req, "rdata", rdata, e_rdata);
    chk(req, "ack_vec", ackv, e_ack);
    chk(req, "eoi_vec", eoiv, e_eoi);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus(input bit w, input int a, input int d);
    sel = 1'b1; wr = w; addr = 2'(a); wdata = DW'(d);
    cycle();
  endtask

  task automatic line(input int i, input bit p, input bit e, input int pr, input bit mine);
    pend[i] = p; en[i] = e; prio[i*PW +: PW] = PW'(pr);
    for (int c = 0; c < NC; c++) tgt[i*NC+c] = (c == ME) ? mine : 1'b1;
  endtask

  initial begin
    #(8*150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pend = '0; en = '0; prio = '0; tgt = '0;
    sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    req = "R1"; // reset state
    chk(req, "irq", irq, 0); chk(req, "rdata", rdata, 0);
    chk(req, "ack_vec", ackv, 0); chk(req, "eoi_vec", eoiv, 0);
    bus(1'b0, 2, 0);
    req = "R6"; line(3, 1, 1, 'h40, 1); cycle();      // mask 0 blocks
    bus(1'b1, 2, 'h40); cycle();                     // equal does not pass
    bus(1'b1, 2, 'h141); cycle();                    // R12 low bits 0x41
    req = "R12"; bus(1'b0, 2, 0); bus(1'b0, 3, 0);
    req = "R2"; line(5, 1, 1, 'h20, 1); cycle();
    req = "R3"; line(2, 1, 1, 'h20, 1); cycle();
    req = "R4"; line(1, 1, 1, 'h10, 0); cycle();
    req = "R5"; line(0, 1, 0, 'h05, 1); line(6, 0, 1, 'h01, 1); cycle();
    req = "R7"; bus(1'b0, 0, 0);                     // claims line 2, id 34
    req = "R9"; cycle(); bus(1'b0, 0, 0);
    req = "R11"; bus(1'b1, 1, 35); cycle();
    req = "R10"; bus(1'b1, 1, 34); cycle();
    req = "R11"; bus(1'b1, 1, 34);
    req = "R8"; pend = '0; bus(1'b0, 0, 0);
    req = "R7";
    for (int k = 0; k < 3000; k++) begin
      if (k % 7 == 0) begin
        pend = N'($urandom); en = N'($urandom | $urandom);
        for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'($urandom_range(0, 15) * 16);
        tgt = (N*NC)'({$urandom, $urandom});
      end
      case ($urandom_range(0, 5))
        0, 1: bus(1'b0, 0, 0);
        2:    bus(1'b1, 1, ($urandom_range(0, 1) == 1) ? 32 + m_act : $urandom_range(30, 50));
        3:    bus(1'b1, 2, $urandom_range(0, 511));
        4:    bus(1'b0, $urandom_range(2, 3), 0);
        default: cycle();
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule